// File: doc/BRIEF.md
# Serial-Programmed Twelve-Channel Trim Code Bank

This block is the digital front end for a bank of twelve voltage-trim converters. A host writes it through a three-wire serial link made of a data line, a serial clock and an active-low select. Each transfer is one 12-bit frame. The first four bits give a channel address and the last eight bits give the new code. Both fields are sent most-significant bit first. When the select line returns high after exactly twelve bits, the addressed channel register takes the new code. Address value `a` selects channel `a + 1`. Address values above 11 do nothing.

The serial pins are sampled by the block's own system clock. A two-stage synchronizer feeds a framing state machine with three states:
- `ST_IDLE`: select is high. The machine waits.
- `ST_SHIFT`: the select line has gone low. The shift register and bit counter were cleared on entry, and each rising serial-clock edge shifts one bit in.
- `ST_COMMIT`: a one-cycle write slot that follows the rise of select.

The transitions are:
- `IDLE→SHIFT` when select is seen low.
- `SHIFT→COMMIT` when select is seen high.
- `COMMIT→IDLE` unconditionally.

An asynchronous active-low reset presets every channel to midscale (0x80). The power-down input forces the code bus to zero and raises the shutdown status. The stored codes are kept, and serial writes are still accepted during power-down. `pwr_down` must be synchronous to `clk`.

Top module: `trim_bank`

## Requirements
- R1: The block holds twelve independent 8-bit channel codes. Channel n (1..12) appears on `chan_code[8*(n-1)+7 : 8*(n-1)]`.
- R2: A frame is sampled on rising `ser_clk` edges while `ser_cs_n` is low. Its first four bits are the address and its last eight bits are the data, each field sent most-significant bit first.
- R3: Address value a (0..11) writes channel a+1. Address 0 writes channel 1, and address 11 writes channel 12.
- R4: A write changes only the addressed channel. Channels may be written in any order.
- R5: The addressed channel changes only after `ser_cs_n` rises. The new code is visible within 6 `clk` cycles of that rise, and no channel changes while the frame is still open.
- R6: A frame that holds fewer or more than 12 bits when `ser_cs_n` rises is discarded, and no channel changes.
- R7: A frame with address 12..15 is discarded, and no channel changes.
- R8: Asserting `rst_n` low sets every channel code to 0x80 at once, without waiting for a clock edge.
- R9: While `pwr_down` is high, `chan_code` is all zeros and `shdn_stat` is 1. Stored codes are kept, and they reappear when `pwr_down` falls.
- R10: Frames received during power-down are stored, and they become visible when `pwr_down` falls.
- R11: Each frame starts from a cleared shift register and bit count, so a good frame is decoded correctly after a discarded one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset; presets every channel to midscale |
| ser_din | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial clock; a bit is taken on each rising edge |
| ser_cs_n | input | 1 | Active-low frame select; its rise ends the frame |
| pwr_down | input | 1 | Power-down request, synchronous to `clk` |
| chan_code | output | 96 | Twelve 8-bit channel codes; channel 1 in the low byte |
| shdn_stat | output | 1 | High while power-down is in force |

## Verification
The in-line assertions check several properties on every clock:
- a channel that is not addressed by a write keeps its value (R4);
- an out-of-range write leaves the whole bank untouched (R7);
- a write only follows the shifting state (R5);
- the bit counter stays within its saturation limit (R6);
- each new frame starts from a cleared count (R11);
- the bank holds still during power-down when no write is issued (R9).

Several behaviours can only be shown by the bench's scenarios, which compare the ports against a reference model on every cycle:
- the bit order and the one-based address mapping;
- rejection of short and long frames;
- the asynchronous midscale preset;
- the zero blanking while powered down;
- the return of both old and newly written codes after power-down.

// File: rtl/trim_pkg.sv
package trim_pkg;
    localparam int NUM_CH_DEF = 12;
    localparam int ADDR_W_DEF = 4;
    localparam int DATA_W_DEF = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } frm_state_e;
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
    parameter int          W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // two flops per bit; reset values match an idle bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= INIT;
            stage2_q <= INIT;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/trim_frame_fsm.sv
module trim_frame_fsm
    import trim_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              din_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int FRAME_BITS = ADDR_W + DATA_W;
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    frm_state_e              state_q, state_d;
    logic                    sclk_q;
    logic                    sclk_rise;
    logic [FRAME_BITS-1:0]   shift_q;
    logic [CNT_W-1:0]        cnt_q;

    assign sclk_rise = sclk_s & ~sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!cs_n_s) state_d = ST_SHIFT;
            ST_SHIFT:  if (cs_n_s)  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // shift register and saturating bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            shift_q <= '0;
            cnt_q   <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (state_q == ST_IDLE && !cs_n_s) begin
                shift_q <= '0;
                cnt_q   <= '0;
            end else if (state_q == ST_SHIFT && !cs_n_s && sclk_rise) begin
                shift_q <= {shift_q[FRAME_BITS-2:0], din_s};
                if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = shift_q[FRAME_BITS-1 -: ADDR_W];
        wr_data = shift_q[DATA_W-1:0];
        unique case (state_q)
            ST_IDLE:   wr_en = 1'b0;
            ST_SHIFT:  wr_en = 1'b0;
            ST_COMMIT: wr_en = (cnt_q == CNT_W'(FRAME_BITS));
            default:   wr_en = 1'b0;
        endcase
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CNT_MAX)); // R6
    AST_WRITE_FOLLOWS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(state_q) == ST_SHIFT); // R5
    AST_FRAME_STARTS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && $past(state_q) == ST_IDLE) |-> cnt_q == '0); // R11
endmodule

// File: rtl/trim_regfile.sv
module trim_regfile
    import trim_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*DATA_W-1:0] regs_flat
);
    localparam logic [DATA_W-1:0] MIDSCALE = {1'b1, {(DATA_W-1){1'b0}}};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [DATA_W-1:0] code_q;
        logic              hit;

        assign hit = wr_en && (wr_addr == ADDR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   code_q <= MIDSCALE;
            else if (hit) code_q <= wr_data;
        end

        assign regs_flat[g*DATA_W +: DATA_W] = code_q;

        AST_UNADDRESSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == ADDR_W'(g)) |=> $stable(regs_flat[g*DATA_W +: DATA_W])); // R4
    end

    AST_OUT_OF_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) >= NUM_CH) |=> $stable(regs_flat)); // R7
endmodule

// File: rtl/trim_bank.sv
module trim_bank
    import trim_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_din,
    input  logic                     ser_clk,
    input  logic                     ser_cs_n,
    input  logic                     pwr_down,
    output logic [NUM_CH*DATA_W-1:0] chan_code,
    output logic                     shdn_stat
);
    localparam int BUS_W = NUM_CH * DATA_W;

    logic [2:0]        pins_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [BUS_W-1:0]  regs_flat;

    // bit 2: select (idles high), bit 1: serial clock, bit 0: data
    trim_sync #(.W(3), .INIT(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_cs_n, ser_clk, ser_din}),
        .q     (pins_s)
    );

    trim_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s[2]),
        .sclk_s  (pins_s[1]),
        .din_s   (pins_s[0]),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    trim_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

    // power-down blanks the bus; storage is untouched
    always_comb begin
        chan_code = pwr_down ? '0 : regs_flat;
        shdn_stat = pwr_down;
    end

    AST_SHUTDOWN_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !wr_en) |=> $stable(regs_flat)); // R9
endmodule

// File: tb/trim_bank_tb.sv
module trim_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_cs_n = 1'b1;
    logic        pwr_down = 1'b0;
    logic [95:0] chan_code;
    logic        shdn_stat;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    running  = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R8";

    always #10 clk = ~clk;

    trim_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_din   (ser_din),
        .ser_clk   (ser_clk),
        .ser_cs_n  (ser_cs_n),
        .pwr_down  (pwr_down),
        .chan_code (chan_code),
        .shdn_stat (shdn_stat)
    );

    // ---------------- behavioural reference model ----------------
    bit        h_cs[$];
    bit        h_sck[$];
    bit        h_din[$];
    int        m_mode;     // 0 waiting, 1 collecting, 2 writing
    int        m_bits;
    int        m_word;
    logic [7:0] m_code[12];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_cs  = '{1'b1, 1'b1, 1'b1};
            h_sck = '{1'b0, 1'b0, 1'b0};
            h_din = '{1'b0, 1'b0, 1'b0};
            m_mode = 0; m_bits = 0; m_word = 0;
            foreach (m_code[i]) m_code[i] = 8'h80;
        end else begin
            // pins seen by the frame logic lag the pads by two clocks
            if (m_mode == 2) begin
                if (m_bits == 12 && ((m_word >> 8) & 15) < 12)
                    m_code[(m_word >> 8) & 15] = 8'(m_word & 255);
                m_mode = 0;
            end else if (m_mode == 0) begin
                if (!h_cs[1]) begin m_mode = 1; m_bits = 0; m_word = 0; end
            end else begin
                if (h_cs[1]) m_mode = 2;
                else if (h_sck[1] && !h_sck[0]) begin
                    m_word = ((m_word << 1) | int'(h_din[1])) & 12'hFFF;
                    if (m_bits < 13) m_bits++;
                end
            end
            h_cs.push_back(ser_cs_n);  void'(h_cs.pop_front());
            h_sck.push_back(ser_clk);  void'(h_sck.pop_front());
            h_din.push_back(ser_din);  void'(h_din.pop_front());
        end
    end

    function automatic logic [95:0] model_bus();
        logic [95:0] b;
        for (int i = 0; i < 12; i++) b[i*8 +: 8] = m_code[i];
        return pwr_down ? 96'h0 : b;
    endfunction

    always @(negedge clk) begin
        if (running && rst_n) begin
            n_checks++;
            if (chan_code !== model_bus() || shdn_stat !== pwr_down) begin
                n_fails++;
                $display("FAIL %s cycle compare: actual %h/%b expected %h/%b",
                         cur_req, chan_code, shdn_stat, model_bus(), pwr_down);
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [7:0] ch(int n);
        return chan_code[(n-1)*8 +: 8];
    endfunction

    task automatic chk(string req, int n, logic [7:0] exp);
        n_checks++;
        if (ch(n) !== exp) begin
            n_fails++;
            $display("FAIL %s channel %0d: actual %h expected %h", req, n, ch(n), exp);
        end
    endtask

    task automatic chk_all(string req, logic [7:0] exp[12]);
        for (int i = 0; i < 12; i++) chk(req, i + 1, exp[i]);
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // shift nb bits (MSB of the nb-bit value first); optionally keep select low
    task automatic frame_open(logic [15:0] bits, int nb);
        ser_cs_n = 1'b0; ticks(3);
        for (int i = nb - 1; i >= 0; i--) begin
            ser_din = bits[i]; ser_clk = 1'b0; ticks(3);
            ser_clk = 1'b1; ticks(3);
        end
        ser_clk = 1'b0; ticks(3);
    endtask

    task automatic frame_close();
        ser_cs_n = 1'b1; ser_din = 1'b0; ticks(8);
    endtask

    task automatic send(logic [3:0] a, logic [7:0] d);
        frame_open({4'h0, a, d}, 12);
        frame_close();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    logic [7:0] exp[12];

    initial begin
        foreach (exp[i]) exp[i] = 8'h80;
        ticks(3);
        rst_n = 1'b1;
        running = 1'b1;
        ticks(3);

        cur_req = "R8";
        chk_all("R8", exp);
        n_checks++;
        if (shdn_stat !== 1'b0) begin
            n_fails++; $display("FAIL R9 reset status: actual %b expected 0", shdn_stat);
        end

        cur_req = "R3"; // address 0 -> channel 1, address 11 -> channel 12
        send(4'd0, 8'h3C);  exp[0] = 8'h3C;
        chk("R3", 1, 8'h3C);
        chk_all("R4", exp);
        send(4'd11, 8'hA5); exp[11] = 8'hA5;
        chk("R3", 12, 8'hA5);

        cur_req = "R2"; // bit order: 0x01 must not land as 0x80
        send(4'd9, 8'h01);  exp[9] = 8'h01;
        chk("R2", 10, 8'h01);
        send(4'd5, 8'h5A);  exp[5] = 8'h5A;
        send(4'd2, 8'hC3);  exp[2] = 8'hC3;
        send(4'd7, 8'hF0);  exp[7] = 8'hF0;
        cur_req = "R1";
        chk_all("R1", exp);
        cur_req = "R4";
        send(4'd5, 8'h11);  exp[5] = 8'h11;
        chk_all("R4", exp);

        cur_req = "R5"; // nothing moves while select is still low
        frame_open({4'h0, 4'd1, 8'h99}, 12);
        ticks(6);
        chk("R5", 2, 8'h80);
        ser_cs_n = 1'b1; ticks(6);
        exp[1] = 8'h99;
        chk("R5", 2, 8'h99);
        ticks(4);

        cur_req = "R6";
        frame_open({4'h0, 4'd3, 8'h44} >> 1, 11); frame_close();
        chk_all("R6", exp);
        frame_open({3'b0, 4'd3, 8'h44, 1'b1}, 13); frame_close();
        chk_all("R6", exp);

        cur_req = "R11";
        send(4'd3, 8'h6E);  exp[3] = 8'h6E;
        chk_all("R11", exp);

        cur_req = "R7";
        send(4'd12, 8'h00);
        send(4'd15, 8'hFF);
        chk_all("R7", exp);

        cur_req = "R9";
        pwr_down = 1'b1; ticks(2);
        for (int i = 1; i <= 12; i++) chk("R9", i, 8'h00);
        n_checks++;
        if (shdn_stat !== 1'b1) begin
            n_fails++; $display("FAIL R9 status: actual %b expected 1", shdn_stat);
        end
        cur_req = "R10";
        send(4'd4, 8'h77);  exp[4] = 8'h77;
        chk("R10", 5, 8'h00);
        pwr_down = 1'b0; ticks(1);
        chk("R9", 1, 8'h3C);
        chk("R10", 5, 8'h77);
        chk_all("R9", exp);

        cur_req = "R8"; // asynchronous preset, checked between edges
        @(negedge clk); #2;
        rst_n = 1'b0;
        #3;
        foreach (exp[i]) exp[i] = 8'h80;
        chk_all("R8", exp);
        ticks(2);
        rst_n = 1'b1;
        ticks(3);
        send(4'd6, 8'h2B);  exp[6] = 8'h2B;
        chk_all("R3", exp);

        ticks(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule